// File: doc/BRIEF.md
# Trimmed Timekeeping Divider

This block turns a 32768 Hz timebase into the tick strobes a watch needs: 8192 Hz, 32 Hz, 1 Hz, a minute strobe and a slower housekeeping strobe every four minutes. Rate trimming is digital. A crystal that runs fast is corrected by deleting a chosen number of 8192 Hz pulses, from 0 to 127, once per calibration period. Each deleted pulse removes one prescaler interval, about 0.122 ms of accumulated time. The calibration period is one minute or two minutes, chosen by a single select bit. Because the deletion happens ahead of every later stage, the 32 Hz stream stretches visibly once per period.

The trim count and the period select come from non-volatile storage and are held static. The block samples the count at each calibration boundary. A swallow state machine with two states, `ST_IDLE` and `ST_SWALLOW`, controls the deletion. The transition `idle->swallow` is taken when a calibration boundary arrives with a non-zero count, and the count is loaded into a down-counter at that moment. The transition `swallow->swallow` consumes one raw 8192 Hz pulse each time while more than one remains. The transition `swallow->idle` consumes the last pulse to be deleted. In the `idle->idle` case, a boundary with a zero count, nothing happens.

A fast-test select makes the housekeeping strobe fire on every 1 Hz strobe. This lets mechanics and adaptation logic be exercised quickly. All strobes are synchronous and one input-clock cycle wide.

Top module: `watch_trim_divider`

## Requirements
- R1: While reset is asserted all five strobe outputs are 0.
- R2: With no deletion in progress, the 8192 Hz strobe fires once every PRE_DIV input clocks and is never high on two consecutive cycles.
- R3: The 32 Hz strobe fires on every MID_DIV-th kept 8192 Hz strobe, the 1 Hz strobe on every LOW_DIV-th 32 Hz strobe, and the minute strobe on every SEC_DIV-th 1 Hz strobe. Each slower strobe coincides with a strobe of every faster output.
- R4: With period select 0 every minute strobe is a calibration boundary. With period select 1 only every second minute strobe after reset (the 2nd, 4th, ...) is a boundary.
- R5: At a boundary with count n greater than 0, the n raw 8192 Hz pulses that immediately follow are deleted. The next 8192 Hz strobe after the boundary minute strobe therefore comes PRE_DIV*(n+1) clocks after it.
- R6: A count of 0 deletes nothing, so consecutive minute strobes are exactly PRE_DIV*MID_DIV*LOW_DIV*SEC_DIV clocks apart.
- R7: Every minute, including one that contains a deletion, holds exactly MID_DIV*LOW_DIV*SEC_DIV kept 8192 Hz strobes. A period that follows a boundary with count n is PRE_DIV*n clocks longer than a plain minute.
- R8: With fast-test 0, the housekeeping strobe fires together with every EVT_DIV-th minute strobe.
- R9: With fast-test 1, the housekeeping strobe fires together with every 1 Hz strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz timebase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trim_count_i | input | TRIM_W (7) | Number of 8192 Hz pulses to delete per period, unsigned |
| period_two_min_i | input | 1 | 0: one-minute calibration period, 1: two-minute period |
| fast_test_i | input | 1 | 1: housekeeping strobe follows the 1 Hz strobe |
| tick_8k_o | output | 1 | 8192 Hz strobe after deletion |
| tick_32_o | output | 1 | 32 Hz strobe |
| tick_1s_o | output | 1 | 1 Hz strobe |
| tick_min_o | output | 1 | Minute strobe |
| tick_evt_o | output | 1 | Four-minute housekeeping strobe |

## Verification
The bench builds the block with PRE_DIV=4, MID_DIV=4, LOW_DIV=4, SEC_DIV=3 and EVT_DIV=2. At these values a "minute" is 192 clocks, so four minutes fit in a few thousand cycles, even with the largest count of 127. Both period selects, both test modes, and counts of 0, 1, 5, 9 and 127 can then be run through several calibration boundaries. For each case the bench measures the exact stretch of the period, the start of the deletion burst and the kept-pulse totals.

// File: rtl/wtd_pkg.sv
package wtd_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_SWALLOW = 1'b1
    } swl_state_t;

    typedef struct packed {
        logic s8k;
        logic s32;
        logic s1;
        logic smin;
        logic sevt;
    } strobe_t;

endpackage

// File: rtl/wtd_prescale.sv
module wtd_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic raw_o
);
    localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign raw_o = (cnt_q == LAST);

    assert_raw_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        raw_o |=> !raw_o);

endmodule

// File: rtl/wtd_div_stage.sv
module wtd_div_stage #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic carry_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign carry_o = step_i && (cnt_q == LAST);

    assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q));

endmodule

// File: rtl/wtd_swallow.sv
module wtd_swallow
    import wtd_pkg::*;
#(
    parameter int TRIM_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic              boundary_i,
    input  logic [TRIM_W-1:0] count_i,
    output logic              keep_o
);
    swl_state_t        state_q, state_d;
    logic [TRIM_W-1:0] left_q, left_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (boundary_i && (count_i != '0)) begin
                    state_d = ST_SWALLOW;
                    left_d  = count_i;
                end
            end
            ST_SWALLOW: begin
                if (raw_i) begin
                    left_d = left_q - 1'b1;
                    if (left_q == TRIM_W'(1)) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                left_d  = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:    keep_o = raw_i;
            ST_SWALLOW: keep_o = 1'b0;
            default:    keep_o = raw_i;
        endcase
    end

    assert_burst_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWALLOW) |-> (left_q != '0));

    assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && boundary_i && count_i == '0) |=> (state_q == ST_IDLE));

    assert_burst_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && boundary_i && count_i != '0) |=> (state_q == ST_SWALLOW && left_q == $past(count_i)));

endmodule

// File: rtl/watch_trim_divider.sv
module watch_trim_divider
    import wtd_pkg::*;
#(
    parameter int PRE_DIV = 4,
    parameter int MID_DIV = 256,
    parameter int LOW_DIV = 32,
    parameter int SEC_DIV = 60,
    parameter int EVT_DIV = 4,
    parameter int TRIM_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIM_W-1:0] trim_count_i,
    input  logic              period_two_min_i,
    input  logic              fast_test_i,
    output logic              tick_8k_o,
    output logic              tick_32_o,
    output logic              tick_1s_o,
    output logic              tick_min_o,
    output logic              tick_evt_o
);
    localparam int NSTG = 3;
    localparam int STG_DIV [NSTG] = '{MID_DIV, LOW_DIV, SEC_DIV};

    logic            raw8;
    logic            keep8;
    logic [NSTG:0]   step;
    logic            par_carry;
    logic            evt_carry;
    logic            boundary;
    strobe_t         strb_d, strb_q;

    wtd_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_o (raw8)
    );

    wtd_swallow #(.TRIM_W(TRIM_W)) u_swl (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (raw8),
        .boundary_i (boundary),
        .count_i    (trim_count_i),
        .keep_o     (keep8)
    );

    assign step[0] = keep8;

    for (genvar gi = 0; gi < NSTG; gi++) begin : g_chain
        wtd_div_stage #(.DIV(STG_DIV[gi])) u_stg (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_i  (step[gi]),
            .carry_o (step[gi+1])
        );
    end

    wtd_div_stage #(.DIV(2)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step[NSTG]),
        .carry_o (par_carry)
    );

    wtd_div_stage #(.DIV(EVT_DIV)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step[NSTG]),
        .carry_o (evt_carry)
    );

    assign boundary = period_two_min_i ? par_carry : step[NSTG];

    always_comb begin
        strb_d.s8k  = step[0];
        strb_d.s32  = step[1];
        strb_d.s1   = step[2];
        strb_d.smin = step[3];
        strb_d.sevt = fast_test_i ? step[2] : evt_carry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= '0;
        end else begin
            strb_q <= strb_d;
        end
    end

    assign tick_8k_o  = strb_q.s8k;
    assign tick_32_o  = strb_q.s32;
    assign tick_1s_o  = strb_q.s1;
    assign tick_min_o = strb_q.smin;
    assign tick_evt_o = strb_q.sevt;

    assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_8k_o |=> !tick_8k_o);

    assert_nest_32_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_32_o |-> tick_8k_o);

    assert_nest_1s_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1s_o |-> tick_32_o);

    assert_nest_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_min_o |-> tick_1s_o);

    assert_evt_on_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_test_i && tick_evt_o) |-> tick_min_o);

    assert_evt_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_test_i && tick_evt_o) |-> tick_1s_o);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (strb_q == '0));

endmodule

// File: tb/watch_trim_divider_bench.sv
module watch_trim_divider_bench;

    localparam int PRE = 4;
    localparam int MID = 4;
    localparam int LOW = 4;
    localparam int SEC = 3;
    localparam int EVT = 2;
    localparam int TW  = 7;
    localparam int MIN_CYC = PRE * MID * LOW * SEC;
    localparam int NVEC = 7;
    // columns: trim count, period select, fast test
    localparam int VEC [NVEC][3] = '{
        '{0,   0, 0},
        '{1,   0, 0},
        '{5,   0, 0},
        '{3,   1, 0},
        '{127, 1, 0},
        '{0,   0, 1},
        '{9,   0, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] trim_count = '0;
    logic          period_sel = 1'b0;
    logic          fast_test = 1'b0;
    logic          t8, t32, t1, tmin, tevt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    watch_trim_divider #(
        .PRE_DIV(PRE), .MID_DIV(MID), .LOW_DIV(LOW),
        .SEC_DIV(SEC), .EVT_DIV(EVT), .TRIM_W(TW)
    ) u_watch_trim_divider (
        .clk              (clk),
        .rst_n            (rst_n),
        .trim_count_i     (trim_count),
        .period_two_min_i (period_sel),
        .fast_test_i      (fast_test),
        .tick_8k_o        (t8),
        .tick_32_o        (t32),
        .tick_1s_o        (t1),
        .tick_min_o       (tmin),
        .tick_evt_o       (tevt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int n, input bit sel, input bit fst);
        int cyc = 0;
        int nm = 0;
        int ne = 0;
        int mt [4];
        int et [2];
        int c8 = 0, c32 = 0, c1 = 0;
        int cal_idx;
        int mark = 0;
        bit wait_tick = 1'b0;
        int gap = -1;
        int exp_d12, exp_d23, exp_evt;
        rst_n = 1'b0;
        trim_count = TW'(n);
        period_sel = sel;
        fast_test = fst;
        repeat (3) @(negedge clk);
        chk({t8, t32, t1, tmin, tevt} == 5'b0, "R1 reset quiet", int'({t8, t32, t1, tmin, tevt}), 0);
        rst_n = 1'b1;
        cal_idx = sel ? 2 : 1;
        while ((nm < 4 || ne < 2) && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (t8 && wait_tick && cyc > mark) begin
                gap = cyc - mark;
                wait_tick = 1'b0;
            end
            if (nm == 1) begin
                if (t8)  c8++;
                if (t32) c32++;
                if (t1)  c1++;
            end
            if (tevt && ne < 2) begin
                et[ne] = cyc;
                ne++;
            end
            if (tmin && nm < 4) begin
                mt[nm] = cyc;
                nm++;
                if (nm == cal_idx) begin
                    mark = cyc;
                    wait_tick = 1'b1;
                end
            end
        end
        chk(nm == 4 && ne == 2, "R3 strobes seen", nm * 10 + ne, 42);
        if (nm == 4 && ne == 2) begin
            exp_d12 = sel ? MIN_CYC : MIN_CYC + PRE * n;
            exp_d23 = MIN_CYC + PRE * n;
            chk(mt[1] - mt[0] == exp_d12, (n == 0) ? "R6 plain minute" : "R4 period stretch m1-m2", mt[1] - mt[0], exp_d12);
            chk(mt[2] - mt[1] == exp_d23, "R7 period stretch m2-m3", mt[2] - mt[1], exp_d23);
            chk(c8 == MID * LOW * SEC, "R7 kept 8k per minute", c8, MID * LOW * SEC);
            chk(c32 == LOW * SEC, "R3 32Hz per minute", c32, LOW * SEC);
            chk(c1 == SEC, "R3 1Hz per minute", c1, SEC);
            chk(gap == PRE * (n + 1), (n == 0) ? "R2 8k spacing" : "R5 burst start", gap, PRE * (n + 1));
            if (fst) begin
                exp_evt = PRE * MID * LOW;
                chk(et[1] - et[0] == exp_evt, "R9 fast evt", et[1] - et[0], exp_evt);
            end else begin
                exp_evt = sel ? (2 * MIN_CYC + PRE * n) : 2 * (MIN_CYC + PRE * n);
                chk(et[1] - et[0] == exp_evt, "R8 evt interval", et[1] - et[0], exp_evt);
                chk(et[0] == mt[1], "R8 evt on 2nd minute", et[0], mt[1]);
            end
        end
    endtask

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < NVEC; i++) begin
            run_case(VEC[i][0], VEC[i][1] != 0, VEC[i][2] != 0);
        end
        // directed: reset mid-run clears all strobes (R1)
        rst_n = 1'b1;
        trim_count = TW'(2);
        period_sel = 1'b0;
        fast_test = 1'b0;
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({t8, t32, t1, tmin, tevt} == 5'b0, "R1 async reset mid-run", int'({t8, t32, t1, tmin, tevt}), 0);
        // directed: first 8k tick after release lands PRE clocks later (R2)
        rst_n = 1'b1;
        begin
            int first = 0;
            for (int k = 1; k <= 2 * PRE && first == 0; k++) begin
                @(negedge clk);
                if (t8) first = k;
            end
            chk(first == PRE, "R2 first 8k tick", first, PRE);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule